// File: doc/BRIEF.md
# DRAM Initialization and Refresh Scheduler

This block decides when an asynchronous RAS/CAS DRAM may be used and when it must be refreshed. The block does not drive any memory pins. It hands refresh work to a separate access sequencer through a request/grant pair.

After reset the block stays silent for a power-up pause. It then requests a fixed number of warm-up refreshes, and only after the last of these is granted does it raise `ready`. In normal operation it raises one refresh request per distributed interval. When a grant arrives late, the owed refreshes are counted and the interval grid keeps its original phase.

Software-side logic can ask for self refresh. The block first requests a bracketing group of refreshes, then holds self refresh. On exit it requests the same bracketing group again. One such refresh suffices in distributed mode. Burst mode sets the group size to the full row count. If self refresh lasted long enough, the block also flags that the next precharge must use the long self-refresh precharge time. All intervals are parameters in clock cycles, and their defaults are derived from a clock-frequency parameter.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and after it is released, `ref_req`, `ready`, `sr_active` and `long_pre` are all 0. `ref_req` first goes high exactly PAUSE_CYC clock edges after reset release, and `sr_enter_req` during the pause has no effect.
- R2: After the pause, exactly WARMUP_REFS granted refreshes are required. `ready` stays 0 while any is still outstanding and is 1 in the cycle after the edge that accepts the last grant.
- R3: In normal operation (`ready`=1), a refresh request is raised every REF_INT_CYC cycles. The first request comes REF_INT_CYC cycles after normal operation begins.
- R4: A raised `ref_req` stays high until a grant is accepted, which happens on an edge where `ref_req` and `ref_gnt` are both 1. A `ref_gnt` pulse while `ref_req` is 0 changes nothing.
- R5: Refreshes that are not granted accumulate, up to OWED_MAX. `ref_req` stays high until all of them are granted. Later requests still fall on the original REF_INT_CYC grid.
- R6: A pulse on `sr_enter_req` in normal operation drops `ready` at once. The block then requests BRACKET_REFS refreshes, and after the last grant `sr_active` goes to 1.
- R7: A pulse on `sr_exit_req` while `sr_active`=1 clears `sr_active`. The block then requests BRACKET_REFS refreshes, and `ready` returns after the last grant. `sr_exit_req` outside self refresh is ignored.
- R8: `long_pre` goes to 1 at self-refresh exit when at least LONG_SR_CYC-1 cycles had been spent in self refresh before the exit edge. It goes back to 0 on the first accepted grant after exit. After shorter self refresh it stays 0.
- R9: While `sr_active`=1, `ref_req` is 0 no matter how long self refresh lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_enter_req | input | 1 | One-cycle request to enter self refresh |
| sr_exit_req | input | 1 | One-cycle request to leave self refresh |
| ref_gnt | input | 1 | Sequencer accepts the pending refresh |
| ref_req | output | 1 | A refresh cycle is wanted |
| ready | output | 1 | Memory may be used for normal accesses |
| sr_active | output | 1 | Self refresh is in effect |
| long_pre | output | 1 | Use the long self-refresh precharge time next |

## Verification
The scheduler is exercised with several grant patterns.
- **Prompt grants** show that the request grid is exactly one interval wide.
- **A grant withheld for two extra intervals, followed by a burst of grants,** separates correct owed-refresh counting from a request that is simply dropped or re-timed from the grant.
- **A stray grant with nothing pending** reveals an underflow of the owed count.
- **Self-refresh episodes of short and long duration, each with different grant latencies,** separate the long-precharge decision from the bracketing-refresh count.

Pulses of `sr_enter_req` during the pause and of `sr_exit_req` during normal operation confirm that both are ignored outside their state.

// File: rtl/refsched_pkg.sv
// Shared types and helpers for the refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package refsched_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE   = 3'd0,
        ST_WARM    = 3'd1,
        ST_RUN     = 3'd2,
        ST_SR_PRE  = 3'd3,
        ST_SR_ON   = 3'd4,
        ST_SR_POST = 3'd5
    } rs_state_e;

    // Counter width that never collapses to zero bits.
    function automatic int unsigned width_of(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/refsched_span_cnt.sv
// Interval counter: counts enabled cycles and flags every LIMIT-th one.
// The count is cleared while disabled and wraps after the flag, so the
//   flag recurs on a fixed grid independent of what the flag triggers.
// Assumes: LIMIT >= 1.
module refsched_span_cnt #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    import refsched_pkg::*;

    localparam int unsigned W = width_of(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Advance while enabled, wrap at the last count, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = en && (cnt == LAST);

endmodule

// File: rtl/refsched_owed.sv
// Owed-refresh account: adds one on each interval tick, removes one on
//   each accepted grant, saturates at OWED_MAX and never underflows.
// Assumes: clr has priority; tick and take may coincide.
module refsched_owed #(
    parameter int unsigned OWED_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic take,
    output logic pending
);
    import refsched_pkg::*;

    localparam int unsigned OW = width_of(OWED_MAX + 1);
    localparam logic [OW-1:0] TOP = OW'(OWED_MAX);

    logic [OW-1:0] owed;
    logic          add, sub;

    // Decide this cycle's increment and decrement with guards.
    always_comb begin
        add = tick && (owed != TOP);
        sub = take && (owed != '0);
    end

    // Hold the number of refreshes still owed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owed <= '0;
        end else if (add && !sub) begin
            owed <= owed + 1'b1;
        end else if (sub && !add) begin
            owed <= owed - 1'b1;
        end
    end

    assign pending = (owed != '0);

    // R5: the account never exceeds its ceiling.
    assert_owed_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= TOP);

    // R5: taking the last owed refresh with no new tick empties the account.
    assert_owed_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && take && !tick && owed == OW'(1)) |=> !pending);

endmodule

// File: rtl/refsched_sr_clock.sv
// Self-refresh duration meter: counts cycles while enabled and saturates,
//   reporting whether the long-duration threshold has been reached.
// Assumes: LONG_CYC >= 1; cleared whenever self refresh is not held.
module refsched_sr_clock #(
    parameter int unsigned LONG_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic long_hit
);
    import refsched_pkg::*;

    localparam int unsigned W = width_of(LONG_CYC);
    localparam logic [W-1:0] SAT = W'(LONG_CYC - 1);

    logic [W-1:0] cnt;

    // Count held cycles up to the saturation point.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt != SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign long_hit = (cnt == SAT);

endmodule

// File: rtl/dram_refresh_sched.sv
// Top of the DRAM initialization and refresh scheduler.
// Sequence: power-up pause, warm-up refreshes, periodic distributed
//   refresh, and self refresh bracketed by refresh groups on both sides.
// Assumes: the access sequencer performs one refresh cycle per accepted
//   grant (ref_req && ref_gnt on a clock edge); request inputs are
//   one-cycle pulses synchronous to clk. Defaults follow CLK_MHZ; set
//   BRACKET_REFS to the row count for burst-style bracketing.
module dram_refresh_sched #(
    parameter int unsigned CLK_MHZ      = 100,
    parameter int unsigned PAUSE_CYC    = CLK_MHZ * 200,
    parameter int unsigned REF_INT_CYC  = (CLK_MHZ * 156) / 10,
    parameter int unsigned LONG_SR_CYC  = CLK_MHZ * 100,
    parameter int unsigned WARMUP_REFS  = 8,
    parameter int unsigned BRACKET_REFS = 1,
    parameter int unsigned OWED_MAX     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_enter_req,
    input  logic sr_exit_req,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ready,
    output logic sr_active,
    output logic long_pre
);
    import refsched_pkg::*;

    localparam int unsigned GMAX = (WARMUP_REFS > BRACKET_REFS) ? WARMUP_REFS : BRACKET_REFS;
    localparam int unsigned GW   = width_of(GMAX + 1);
    localparam logic [GW-1:0] WARM_LAST = GW'(WARMUP_REFS - 1);
    localparam logic [GW-1:0] BRKT_LAST = GW'(BRACKET_REFS - 1);

    rs_state_e     state, state_n;
    logic [GW-1:0] gcnt, gcnt_n;
    logic          pause_done, int_tick, owed_pend, long_hit, gnt_ok;

    // Power-up pause timer, running only during the pause.
    refsched_span_cnt #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk(clk), .rst_n(rst_n), .en(state == ST_PAUSE), .done(pause_done)
    );

    // Distributed interval timer, free-running on its grid in normal run.
    refsched_span_cnt #(.LIMIT(REF_INT_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .en(state == ST_RUN), .done(int_tick)
    );

    // Owed refreshes, cleared outside normal run where groups take over.
    refsched_owed #(.OWED_MAX(OWED_MAX)) u_owed (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_RUN),
        .tick(int_tick), .take(gnt_ok), .pending(owed_pend)
    );

    // Self-refresh duration meter.
    refsched_sr_clock #(.LONG_CYC(LONG_SR_CYC)) u_srclk (
        .clk(clk), .rst_n(rst_n), .en(state == ST_SR_ON), .long_hit(long_hit)
    );

    assign gnt_ok = ref_req && ref_gnt;

    // Request and status decode from the current phase.
    always_comb begin
        unique case (state)
            ST_WARM, ST_SR_PRE, ST_SR_POST: ref_req = 1'b1;
            ST_RUN:                         ref_req = owed_pend;
            default:                        ref_req = 1'b0;
        endcase
        ready     = (state == ST_RUN);
        sr_active = (state == ST_SR_ON);
    end

    // Phase sequencing and group grant counting.
    always_comb begin
        state_n = state;
        gcnt_n  = gcnt;
        unique case (state)
            ST_PAUSE: if (pause_done) state_n = ST_WARM;
            ST_WARM: if (gnt_ok) begin
                if (gcnt == WARM_LAST) begin
                    state_n = ST_RUN;
                    gcnt_n  = '0;
                end else begin
                    gcnt_n = gcnt + 1'b1;
                end
            end
            ST_RUN: if (sr_enter_req) state_n = ST_SR_PRE;
            ST_SR_PRE: if (gnt_ok) begin
                if (gcnt == BRKT_LAST) begin
                    state_n = ST_SR_ON;
                    gcnt_n  = '0;
                end else begin
                    gcnt_n = gcnt + 1'b1;
                end
            end
            ST_SR_ON: if (sr_exit_req) state_n = ST_SR_POST;
            ST_SR_POST: if (gnt_ok) begin
                if (gcnt == BRKT_LAST) begin
                    state_n = ST_RUN;
                    gcnt_n  = '0;
                end else begin
                    gcnt_n = gcnt + 1'b1;
                end
            end
            default: state_n = ST_PAUSE;
        endcase
    end

    // Phase and grant-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            gcnt  <= '0;
        end else begin
            state <= state_n;
            gcnt  <= gcnt_n;
        end
    end

    // Long-precharge flag: set at a long self-refresh exit, cleared by next grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            long_pre <= 1'b0;
        end else if (state == ST_SR_ON && sr_exit_req && long_hit) begin
            long_pre <= 1'b1;
        end else if (gnt_ok) begin
            long_pre <= 1'b0;
        end
    end

    // R4: a raised request is not withdrawn without an accepted grant.
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);

    // R2: ready only appears on the edge that accepts a grant.
    assert_ready_on_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(ref_gnt));

    // R9: no refresh is requested while self refresh holds.
    assert_sr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> !ref_req);

    // R8: the long-precharge flag only rises out of self refresh.
    assert_long_after_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_pre) |-> $past(sr_active));

    // R7: self refresh is only left toward a phase that requests refresh.
    assert_exit_brackets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |-> (ref_req && !ready));

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PAUSE  = 50;
    localparam int INTV   = 30;
    localparam int LONG   = 40;
    localparam int WARM   = 8;
    localparam int BRKT   = 2;

    // Self-refresh scenarios: {cycles held, grant latency, long_pre expected}.
    localparam int NV = 4;
    localparam logic [24:0] VECS [NV] = '{
        {16'd20,  8'd0, 1'b0},
        {16'd60,  8'd2, 1'b1},
        {16'd5,   8'd4, 1'b0},
        {16'd100, 8'd1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_enter_req = 1'b0, sr_exit_req = 1'b0, ref_gnt = 1'b0;
    logic ref_req, ready, sr_active, long_pre;
    int   nchk = 0, nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC(PAUSE), .REF_INT_CYC(INTV), .LONG_SR_CYC(LONG),
        .WARMUP_REFS(WARM), .BRACKET_REFS(BRKT), .OWED_MAX(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sr_enter_req(sr_enter_req),
        .sr_exit_req(sr_exit_req), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .ready(ready), .sr_active(sr_active), .long_pre(long_pre)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count negedges until ref_req is seen high (bounded).
    task automatic wait_req(output int c);
        c = 0;
        while (!ref_req && c < 5000) begin
            @(negedge clk);
            c++;
        end
    endtask

    // Wait for a request, delay lat cycles, then grant for one edge.
    task automatic serve(input int lat);
        int c;
        wait_req(c);
        repeat (lat) @(negedge clk);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int c, t;
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        chk("R1 req in reset", ref_req, 0);
        chk("R1 ready in reset", ready, 0);
        chk("R1 sr_active in reset", sr_active, 0);
        chk("R1 long_pre in reset", long_pre, 0);

        // R1: pause length, with a self-refresh request during it ignored
        rst_n = 1'b1;
        sr_enter_req = 1'b1;
        @(negedge clk);
        sr_enter_req = 1'b0;
        wait_req(t);
        chk("R1 pause cycles", t + 1, PAUSE);
        chk("R1 sr_enter ignored in pause", sr_active, 0);

        // R2: warm-up count
        repeat (WARM - 1) serve(0);
        chk("R2 not ready before last warm-up", ready, 0);
        chk("R2 still requesting", ref_req, 1);
        serve(0);
        chk("R2 ready after warm-up", ready, 1);
        chk("R2 no request at start of run", ref_req, 0);

        // R3: first request and interval spacing with prompt grants
        wait_req(c);
        chk("R3 first interval", c, INTV);
        for (int k = 0; k < 2; k++) begin
            serve(0);
            wait_req(c);
            chk("R3 interval spacing", c + 1, INTV);
        end

        // R5/R4: withheld grants accumulate, grid keeps its phase
        repeat (2 * INTV) @(negedge clk);
        chk("R4 request held without grant", ref_req, 1);
        ref_gnt = 1'b1;
        @(negedge clk);
        chk("R5 still owed after one grant", ref_req, 1);
        @(negedge clk);
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R5 drained after three grants", ref_req, 0);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R4 stray grant keeps request low", ref_req, 0);
        wait_req(c);
        chk("R5 grid phase kept", c, INTV - 4);
        serve(0);

        // R7: exit request ignored in normal run
        sr_exit_req = 1'b1;
        @(negedge clk);
        sr_exit_req = 1'b0;
        chk("R7 exit ignored in run (sr_active)", sr_active, 0);
        chk("R7 exit ignored in run (ready)", ready, 1);

        // R6/R7/R8/R9: self-refresh scenarios
        for (int v = 0; v < NV; v++) begin
            int len, lat, exl;
            len = int'(VECS[v][24:9]);
            lat = int'(VECS[v][8:1]);
            exl = int'(VECS[v][0]);
            sr_enter_req = 1'b1;
            @(negedge clk);
            sr_enter_req = 1'b0;
            chk("R6 ready drops on entry", ready, 0);
            chk("R6 bracket request before entry", ref_req, 1);
            repeat (BRKT - 1) serve(lat);
            chk("R6 not yet in self refresh", sr_active, 0);
            serve(lat);
            chk("R6 self refresh after bracket", sr_active, 1);
            repeat (len) @(negedge clk);
            chk("R9 no request in self refresh", ref_req, 0);
            sr_exit_req = 1'b1;
            @(negedge clk);
            sr_exit_req = 1'b0;
            chk("R7 sr_active cleared on exit", sr_active, 0);
            chk("R7 bracket request after exit", ref_req, 1);
            chk("R8 long_pre at exit", long_pre, exl);
            serve(lat);
            chk("R8 long_pre cleared by grant", long_pre, 0);
            chk("R7 not ready mid bracket", ready, 0);
            repeat (BRKT - 1) serve(lat);
            chk("R7 ready after bracket", ready, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule